// File: doc/BRIEF.md
# Cipher Data Port Swap Unit

This unit sits between a host register port and a 128-bit block-cipher core. The host writes 32-bit words one at a time to an input data register. Each word passes through a selectable swap stage (none, half-word, byte or bit) and lands in a 128-bit block, with the first word in the most significant position. After the fourth word, the block goes to the core over a valid/ready channel. The core's 128-bit result returns over a second valid/ready channel. The host then reads it back as four 32-bit words through an output data register, most significant word first. Each word read passes through the same swap stage.

A completion flag rises when a result has been captured, and it stays set until software writes 1 to the clear bit in the control register. The enable bit gates the whole data path. The swap mode can be changed only while the unit is disabled. Clearing the enable bit abandons any block in progress and returns both word counters to zero.

Both core-side channels obey valid/ready. The offered block stays valid, with its data unchanged, until the core raises `blk_ready`. The unit raises `res_ready` only while it waits for a result, so the core may hold `res_valid` as long as it needs. On the host side there is no back-pressure: a write that arrives when it cannot be used is dropped.

Top module: `cipher_data_swap_port`

Register map (word addresses on `wr_addr`/`rd_addr`):

| Address | Register |
|---|---|
| 0 | Control |
| 1 | Status |
| 2 | Input data |
| 3 | Output data |

Control register bits:

| Bits | Field | Access |
|---|---|---|
| 0 | Enable | read/write |
| 2:1 | Swap mode | read/write |
| 3 | Clear completion flag | write 1 to clear, reads 0 |

Status register bits:

| Bits | Field |
|---|---|
| 0 | Completion flag |

`rd_data` is registered. It shows the value of a read one clock after `rd_en`. Reads of the input data register return zero.

## Requirements
- R1: After reset, the control and status registers read 0 (disabled, mode 00, flag clear), an output data read returns 0, and `blk_valid` and `res_ready` are low.
- R2: While enabled, four accepted input data writes form one block. The first word occupies bits [127:96] and the fourth occupies bits [31:0]. `blk_valid` is high in the cycle after the edge that accepts the fourth write.
- R3: Each input word is swapped before packing. The swap mode field takes these values: 00 passes the word through; 01 exchanges the two 16-bit halves; 10 reverses the order of the four bytes; 11 reverses all 32 bits.
- R4: The output data register returns result bits [127:96] first and bits [31:0] on the fourth read. Each word goes through the same swap as R3.
- R5: `blk_valid` stays high with `blk_data` unchanged until `blk_ready` is seen. `res_ready` is high only after the block has been taken and before a result has been captured.
- R6: Capturing a result sets status bit 0. Writing the control register with bit 3 set clears it.
- R7: Input data writes are ignored from the fourth accepted word until the fourth output data read of that result. They do not advance the input word count.
- R8: An output data read while no result is held returns 0 and does not advance the output word count.
- R9: A control write changes the swap mode only if the unit was disabled before that write. Control bit 0 reads back the enable state.
- R10: Writing 0 to the enable bit clears both word counters and drops any pending block or result. Input writes while disabled are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Registered read data, valid one cycle after `rd_en` |
| blk_valid | output | 1 | Packed block offered to the core |
| blk_ready | input | 1 | Core accepts the offered block |
| blk_data | output | 128 | Packed block, first word in the top 32 bits |
| res_valid | input | 1 | Core presents a result |
| res_ready | output | 1 | Unit is waiting for a result |
| res_data | input | 128 | Result block from the core |

## Verification
The assertions watch the following on every cycle:
- the offered block holds steady under back-pressure;
- `res_ready` never overlaps an offered block;
- a captured result always raises the flag;
- an empty output read returns zero;
- the mode stays fixed while enabled;
- nothing is offered, awaited or held while disabled.

Other behaviours need the directed scenarios:
- the word ordering within the block;
- the arithmetic of each swap mode on both paths;
- that dropped writes and early reads leave the counters untouched, shown by the contents of the next block or read sequence;
- recovery after a disable part-way through a block.

// File: rtl/cds_pkg.sv
package cds_pkg;

  typedef enum logic [1:0] {
    SWP_NONE = 2'b00,
    SWP_HALF = 2'b01,
    SWP_BYTE = 2'b10,
    SWP_BIT  = 2'b11
  } swap_mode_e;

  typedef enum logic [1:0] {
    PH_FILL  = 2'b00,
    PH_OFFER = 2'b01,
    PH_AWAIT = 2'b10,
    PH_DRAIN = 2'b11
  } phase_e;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DIN  = 2'd2;
  localparam logic [1:0] A_DOUT = 2'd3;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_MODE_LSB = 1;
  localparam int CTRL_CLR_BIT  = 3;

endpackage

// File: rtl/cds_word_swapper.sv
module cds_word_swapper
  import cds_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  swap_mode_e        mode,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);

  localparam int HALF_W = WORD_W / 2;
  localparam int NBYTES = WORD_W / 8;

  logic [WORD_W-1:0] halves_x;
  logic [WORD_W-1:0] bytes_r;
  logic [WORD_W-1:0] bits_r;

  assign halves_x = {din[HALF_W-1:0], din[WORD_W-1:HALF_W]};

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign bytes_r[b*8 +: 8] = din[(NBYTES-1-b)*8 +: 8];
  end

  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    assign bits_r[i] = din[WORD_W-1-i];
  end

  always_comb begin
    case (mode)
      SWP_HALF: dout = halves_x;
      SWP_BYTE: dout = bytes_r;
      SWP_BIT:  dout = bits_r;
      default:  dout = din;
    endcase
  end

endmodule

// File: rtl/cds_in_packer.sv
module cds_in_packer #(
  parameter int WORD_W    = 32,
  parameter int BLK_WORDS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush,
  input  logic                        push,
  input  logic [WORD_W-1:0]           word,
  input  logic                        blk_ready,
  output logic                        blk_valid,
  output logic [WORD_W*BLK_WORDS-1:0] blk_data,
  output logic                        last_push
);

  localparam int CNT_W = $clog2(BLK_WORDS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BLK_WORDS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign last_push = push && (cnt_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (flush) begin
      cnt_q <= '0;
    end else if (push) begin
      cnt_q <= last_push ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_valid <= 1'b0;
    end else if (flush) begin
      blk_valid <= 1'b0;
    end else if (last_push) begin
      blk_valid <= 1'b1;
    end else if (blk_valid && blk_ready) begin
      blk_valid <= 1'b0;
    end
  end

  for (genvar s = 0; s < BLK_WORDS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        blk_data[(BLK_WORDS-1-s)*WORD_W +: WORD_W] <= '0;
      end else if (push && (cnt_q == CNT_W'(s))) begin
        blk_data[(BLK_WORDS-1-s)*WORD_W +: WORD_W] <= word;
      end
    end
  end

endmodule

// File: rtl/cds_out_unpacker.sv
module cds_out_unpacker #(
  parameter int WORD_W    = 32,
  parameter int BLK_WORDS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush,
  input  logic                        capture,
  input  logic [WORD_W*BLK_WORDS-1:0] res_data,
  input  logic                        pop,
  output logic                        held,
  output logic [WORD_W-1:0]           word,
  output logic                        last_pop
);

  localparam int CNT_W = $clog2(BLK_WORDS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BLK_WORDS - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] slot_q [BLK_WORDS];

  assign last_pop = pop && held && (cnt_q == CNT_LAST);
  assign word     = slot_q[cnt_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      held  <= 1'b0;
    end else if (flush) begin
      cnt_q <= '0;
      held  <= 1'b0;
    end else if (capture) begin
      cnt_q <= '0;
      held  <= 1'b1;
    end else if (pop && held) begin
      cnt_q <= last_pop ? '0 : cnt_q + 1'b1;
      if (last_pop) held <= 1'b0;
    end
  end

  for (genvar s = 0; s < BLK_WORDS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[s] <= '0;
      end else if (capture) begin
        slot_q[s] <= res_data[(BLK_WORDS-1-s)*WORD_W +: WORD_W];
      end
    end
  end

endmodule

// File: rtl/cipher_data_swap_port.sv
module cipher_data_swap_port
  import cds_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int BLK_WORDS = 4,
  localparam int BLK_W    = WORD_W * BLK_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [1:0]        rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              blk_valid,
  input  logic              blk_ready,
  output logic [BLK_W-1:0]  blk_data,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [BLK_W-1:0]  res_data
);

  logic       en_q;
  swap_mode_e mode_q;
  logic       done_q;
  phase_e     phase_q;

  logic ctrl_wr, flush, din_push, last_push, capture, pop, last_pop, out_held;
  logic [WORD_W-1:0] din_swapped, out_raw, out_swapped;
  logic unused_wr_bits;

  assign unused_wr_bits = ^wr_data[WORD_W-1:CTRL_CLR_BIT+1];

  assign ctrl_wr  = wr_en && (wr_addr == A_CTRL);
  assign flush    = ctrl_wr && !wr_data[CTRL_EN_BIT];
  assign din_push = wr_en && (wr_addr == A_DIN) && en_q && (phase_q == PH_FILL);
  assign res_ready = en_q && (phase_q == PH_AWAIT);
  assign capture  = res_valid && res_ready;
  assign pop      = rd_en && (rd_addr == A_DOUT) && out_held;

  // control register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= SWP_NONE;
    end else if (ctrl_wr) begin
      en_q <= wr_data[CTRL_EN_BIT];
      if (!en_q) mode_q <= swap_mode_e'(wr_data[CTRL_MODE_LSB +: 2]);
    end
  end

  // completion flag: set wins over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else if (capture) begin
      done_q <= 1'b1;
    end else if (ctrl_wr && wr_data[CTRL_CLR_BIT]) begin
      done_q <= 1'b0;
    end
  end

  // block life cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FILL;
    end else if (flush) begin
      phase_q <= PH_FILL;
    end else begin
      case (phase_q)
        PH_FILL:  if (last_push)              phase_q <= PH_OFFER;
        PH_OFFER: if (blk_valid && blk_ready) phase_q <= PH_AWAIT;
        PH_AWAIT: if (capture)                phase_q <= PH_DRAIN;
        default:  if (last_pop)               phase_q <= PH_FILL;
      endcase
    end
  end

  cds_word_swapper #(.WORD_W(WORD_W)) u_in_swap (
    .mode (mode_q),
    .din  (wr_data),
    .dout (din_swapped)
  );

  cds_in_packer #(.WORD_W(WORD_W), .BLK_WORDS(BLK_WORDS)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (din_push),
    .word      (din_swapped),
    .blk_ready (blk_ready),
    .blk_valid (blk_valid),
    .blk_data  (blk_data),
    .last_push (last_push)
  );

  cds_out_unpacker #(.WORD_W(WORD_W), .BLK_WORDS(BLK_WORDS)) u_unpack (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .capture  (capture),
    .res_data (res_data),
    .pop      (pop),
    .held     (out_held),
    .word     (out_raw),
    .last_pop (last_pop)
  );

  cds_word_swapper #(.WORD_W(WORD_W)) u_out_swap (
    .mode (mode_q),
    .din  (out_raw),
    .dout (out_swapped)
  );

  // registered read port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (rd_addr)
        A_CTRL:  rd_data <= {{(WORD_W-3){1'b0}}, mode_q, en_q};
        A_STAT:  rd_data <= {{(WORD_W-1){1'b0}}, done_q};
        A_DOUT:  rd_data <= out_held ? out_swapped : '0;
        default: rd_data <= '0;
      endcase
    end
  end

endmodule

// File: rtl/cds_checker.sv
module cds_checker #(
  parameter int WORD_W    = 32,
  parameter int BLK_WORDS = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        rd_en,
  input logic [1:0]                  rd_addr,
  input logic [WORD_W-1:0]           rd_data,
  input logic                        blk_valid,
  input logic                        blk_ready,
  input logic [WORD_W*BLK_WORDS-1:0] blk_data,
  input logic                        res_valid,
  input logic                        res_ready,
  input logic                        en_q,
  input logic [1:0]                  mode_q,
  input logic                        done_q,
  input logic                        out_held,
  input logic                        flush
);

  // R5: an offered block is held steady under back-pressure
  p_offer_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && !blk_ready && !flush) |=> (blk_valid && $stable(blk_data)));

  // R5: never wait for a result while a block is still being offered
  p_ready_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid |-> !res_ready);

  // R6: an accepted result raises the completion flag
  p_done_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> done_q);

  // R8: an output read with nothing held returns zero
  p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (rd_addr == 2'd3) && !out_held) |=> (rd_data == '0));

  // R9: the mode does not move while enabled
  p_mode_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && $past(en_q)) |-> $stable(mode_q));

  // R10: a disabled unit offers, awaits and holds nothing
  p_off_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (!blk_valid && !res_ready && !out_held));

endmodule

bind cipher_data_swap_port cds_checker #(.WORD_W(WORD_W), .BLK_WORDS(BLK_WORDS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_en     (rd_en),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data),
  .blk_valid (blk_valid),
  .blk_ready (blk_ready),
  .blk_data  (blk_data),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .en_q      (en_q),
  .mode_q    (mode_q),
  .done_q    (done_q),
  .out_held  (out_held),
  .flush     (flush)
);

// File: tb/cipher_data_swap_port_test.sv
`timescale 1ns/1ps
module cipher_data_swap_port_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic         rd_en = 1'b0;
  logic [1:0]   rd_addr = '0;
  logic [31:0]  rd_data;
  logic         blk_valid;
  logic         blk_ready;
  logic [127:0] blk_data;
  logic         res_valid = 1'b0;
  logic         res_ready;
  logic [127:0] res_data = '0;

  int n_cmp = 0;
  int n_bad = 0;
  logic stub_ready_en = 1'b1;
  logic [127:0] stub_blk = '0;
  logic stub_have = 1'b0;
  int stub_wait = 0;

  always #10 clk = ~clk;

  assign blk_ready = stub_ready_en;

  cipher_data_swap_port uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .blk_valid(blk_valid), .blk_ready(blk_ready), .blk_data(blk_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
  );

  // core stub: takes a block, answers with its complement a few cycles later
  always @(posedge clk) begin
    if (blk_valid && blk_ready) begin
      stub_blk  <= blk_data;
      stub_have <= 1'b1;
      stub_wait <= 3;
    end else if (stub_have && stub_wait != 0) begin
      stub_wait <= stub_wait - 1;
    end else if (stub_have && !res_valid) begin
      res_valid <= 1'b1;
      res_data  <= ~stub_blk;
    end
    if (res_valid && res_ready) begin
      res_valid <= 1'b0;
      stub_have <= 1'b0;
    end
  end

  function automatic logic [31:0] swp(input logic [1:0] m, input logic [31:0] w);
    logic [31:0] r;
    r = w;
    if (m == 2'b01) r = {w[15:0], w[31:16]};
    if (m == 2'b10) for (int b = 0; b < 4; b++) r[b*8 +: 8] = w[(3-b)*8 +: 8];
    if (m == 2'b11) for (int i = 0; i < 32; i++) r[i] = w[31-i];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int k = 0; k < 40; k++) begin
      reg_rd(2'd1, s);
      if (s[0]) break;
    end
  endtask

  function automatic logic [31:0] ctrl(input logic en, input logic [1:0] m, input logic clr);
    return {28'd0, clr, m, en};
  endfunction

  // full block round trip in one mode
  task automatic t_round_trip(input logic [1:0] m, input logic [31:0] base);
    logic [31:0] w [4];
    logic [127:0] exp_blk;
    logic [31:0] d;
    reg_wr(2'd0, ctrl(1'b0, 2'b00, 1'b0));
    reg_wr(2'd0, ctrl(1'b1, m, 1'b0));
    for (int k = 0; k < 4; k++) begin
      w[k] = base ^ (32'h1111_0000 * (k + 1)) ^ k;
      exp_blk[(3-k)*32 +: 32] = swp(m, w[k]);
      reg_wr(2'd2, w[k]);
    end
    chk("R2 blk_valid after fourth word", 128'(blk_valid), 128'd1);
    wait_done();
    chk("R2 R3 packed and swapped block", stub_blk, exp_blk);
    reg_rd(2'd1, d);
    chk("R6 completion flag set", 128'(d[0]), 128'd1);
    for (int k = 0; k < 4; k++) begin
      reg_rd(2'd3, d);
      chk("R4 output word order and swap", 128'(d), 128'(swp(m, ~exp_blk[(3-k)*32 +: 32])));
    end
    reg_wr(2'd0, ctrl(1'b1, m, 1'b1));
    reg_rd(2'd1, d);
    chk("R6 completion flag cleared", 128'(d[0]), 128'd0);
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    chk("R1 blk_valid low", 128'(blk_valid), 128'd0);
    chk("R1 res_ready low", 128'(res_ready), 128'd0);
    reg_rd(2'd0, d); chk("R1 control reads zero", 128'(d), 128'd0);
    reg_rd(2'd1, d); chk("R1 status reads zero", 128'(d), 128'd0);
    reg_rd(2'd3, d); chk("R1 output data reads zero", 128'(d), 128'd0);
  endtask

  // back-pressure, early reads, dropped writes, frozen mode
  task automatic t_hold_and_ignore();
    logic [31:0] d;
    logic [127:0] exp_blk;
    reg_wr(2'd0, ctrl(1'b0, 2'b00, 1'b0));
    reg_wr(2'd0, ctrl(1'b1, 2'b10, 1'b0));
    stub_ready_en = 1'b0;
    for (int k = 0; k < 4; k++) begin
      exp_blk[(3-k)*32 +: 32] = swp(2'b10, 32'hA0B1_C2D3 + k);
      reg_wr(2'd2, 32'hA0B1_C2D3 + k);
    end
    reg_rd(2'd3, d);
    chk("R8 early output read is zero", 128'(d), 128'd0);
    reg_wr(2'd2, 32'hDEAD_BEEF);
    repeat (4) @(negedge clk);
    chk("R5 block still offered", 128'(blk_valid), 128'd1);
    chk("R5 R7 offered data unchanged", blk_data, exp_blk);
    chk("R5 no res_ready while offering", 128'(res_ready), 128'd0);
    reg_wr(2'd0, ctrl(1'b1, 2'b11, 1'b0));
    reg_rd(2'd0, d);
    chk("R9 mode unchanged while enabled", 128'(d[2:0]), 128'(3'b101));
    stub_ready_en = 1'b1;
    wait_done();
    reg_wr(2'd2, 32'h0BAD_F00D);
    for (int k = 0; k < 4; k++) begin
      reg_rd(2'd3, d);
      chk("R4 R8 readout starts at first word", 128'(d), 128'(swp(2'b10, ~exp_blk[(3-k)*32 +: 32])));
    end
    reg_wr(2'd0, ctrl(1'b1, 2'b10, 1'b1));
    for (int k = 0; k < 4; k++) begin
      exp_blk[(3-k)*32 +: 32] = swp(2'b10, 32'h5500_0000 + k);
      reg_wr(2'd2, 32'h5500_0000 + k);
    end
    wait_done();
    chk("R7 next block holds only fresh words", stub_blk, exp_blk);
    for (int k = 0; k < 4; k++) reg_rd(2'd3, d);
    reg_wr(2'd0, ctrl(1'b1, 2'b10, 1'b1));
  endtask

  // disable part-way through a block
  task automatic t_disable_midway();
    logic [31:0] d;
    logic [127:0] exp_blk;
    reg_wr(2'd0, ctrl(1'b0, 2'b00, 1'b0));
    reg_wr(2'd0, ctrl(1'b1, 2'b01, 1'b0));
    reg_wr(2'd2, 32'h1234_5678);
    reg_wr(2'd2, 32'h9ABC_DEF0);
    reg_wr(2'd0, ctrl(1'b0, 2'b01, 1'b0));
    reg_rd(2'd0, d);
    chk("R9 enable reads back as off", 128'(d[0]), 128'd0);
    reg_wr(2'd2, 32'hFFFF_0000);
    reg_wr(2'd2, 32'hFFFF_0001);
    chk("R10 nothing offered while disabled", 128'(blk_valid), 128'd0);
    reg_wr(2'd0, ctrl(1'b1, 2'b01, 1'b0));
    for (int k = 0; k < 4; k++) begin
      exp_blk[(3-k)*32 +: 32] = swp(2'b01, 32'h7000_0007 * (k + 3));
      reg_wr(2'd2, 32'h7000_0007 * (k + 3));
    end
    wait_done();
    chk("R10 counters restart after disable", stub_blk, exp_blk);
    for (int k = 0; k < 4; k++) reg_rd(2'd3, d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_round_trip(2'b00, 32'h0123_4567);
    t_round_trip(2'b01, 32'h89AB_CDEF);
    t_round_trip(2'b10, 32'hF0E1_D2C3);
    t_round_trip(2'b11, 32'h0123_4567);
    t_hold_and_ignore();
    t_disable_midway();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule